// File: doc/BRIEF.md
# Converter Request Source Arbiter

This block picks the analog channel that a single converter samples next. Requests arrive from three places. A scan source latches a whole bit mask of channels at once, when its selected trigger fires, and then works through them one at a time from the highest channel index down. A queue source holds up to four channel numbers written one at a time, and serves them in the order they were written. A single-shot insertion request names one channel that goes ahead of everything else at the next free slot.

The scan and queue sources each carry a priority level and an enable bit. Whenever the converter is idle, the arbiter compares the sources that are pending and enabled, and issues a one-cycle start strobe with the winning channel and a source tag. It then waits for the converter's done pulse before it grants again. An insertion only takes one slot. The scan or queue sequence it displaced continues afterwards from the entry that was next.

Top module: `adc_req_arbiter`

## Requirements
- R1: After reset no start strobe is issued, `q_full` and `q_ovf` are 0, and both sources hold nothing.
- R2: A scan mask is latched, and ORed into the pending set, only on a pulse of the selected trigger: the internal trigger when `scan_trig_sel` is 0, the external one when it is 1. A pulse on the other trigger has no effect.
- R3: Pending scan channels are granted from the highest index down. A channel's pending bit clears when that channel is granted.
- R4: Queue entries are granted in write order. Up to 4 entries are held.
- R5: A queue write while the queue holds 4 entries is refused. The entry is dropped, `q_full` is 1, and `q_ovf` becomes 1 and stays 1 until reset.
- R6: When the scan and queue sources are both pending and enabled, the one with the larger priority value wins. On equal priority the queue wins.
- R7: A pending insertion beats both sources at the next grant. The interrupted scan sequence then resumes at its next pending channel. A further insertion request is ignored while one is still waiting.
- R8: A disabled source keeps its pending requests but is never granted. After it is enabled again it resumes with those requests.
- R9: Grants are made only while the converter is idle. `conv_start` is high for exactly one cycle, and no further start follows until `conv_done` has been seen.
- R10: `conv_src` tags each grant: 0 for scan, 1 for queue, 2 for insertion. `conv_ch` carries the channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan source enable |
| scan_prio | input | 2 | Scan source priority, larger wins |
| scan_trig_sel | input | 1 | Scan trigger select: 0 internal, 1 external |
| scan_trig_int | input | 1 | Internal event trigger pulse |
| scan_trig_ext | input | 1 | External event trigger pulse |
| scan_mask | input | 16 | Channel mask latched on trigger |
| q_en | input | 1 | Queue source enable |
| q_prio | input | 2 | Queue source priority |
| q_wr | input | 1 | Queue write strobe |
| q_ch | input | 4 | Channel number to enqueue |
| q_full | output | 1 | Queue holds 4 entries |
| q_ovf | output | 1 | Sticky refused-write flag |
| ins_req | input | 1 | Single-shot insertion request |
| ins_ch | input | 4 | Channel to insert |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_ch | output | 4 | Channel of the granted conversion |
| conv_src | output | 2 | Source tag of the granted conversion |
| conv_done | input | 1 | Converter finished pulse |

## Verification
The bench sets up contention by loading sources while they are disabled, then enabling them in the same cycle. This separates a priority comparison from arrival order: a design that let scan win the tie, or that compared priorities the wrong way round, produces the expected channels out of order. An insertion is injected in the middle of a scan sequence. A design that reset or skipped the scan pending set would then lose or repeat channels after the inserted one. The bench also writes a fifth entry into a full queue, ignores triggers that are not selected, and checks that no start overlaps a running conversion. A design that accepted the overflowing entry would emit an extra conversion, and one that aborted a conversion would show two starts before a done.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;

    localparam int PRIO_W = 2;

    typedef enum logic [1:0] {
        SRC_SCAN   = 2'd0,
        SRC_QUEUE  = 2'd1,
        SRC_INSERT = 2'd2
    } src_e;

    typedef struct packed {
        logic ins;
        logic que;
        logic scn;
    } grant_t;

    // queue wins ties
    function automatic logic queue_beats_scan(input logic [PRIO_W-1:0] qp,
                                              input logic [PRIO_W-1:0] sp);
        return qp >= sp;
    endfunction

endpackage

// File: rtl/scan_src.sv
module scan_src #(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_sel,
    input  logic            trig_int,
    input  logic            trig_ext,
    input  logic [NCH-1:0]  mask,
    input  logic            take,
    output logic            pend_any,
    output logic [CH_W-1:0] next_ch
);
    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;
    logic           load;

    assign load     = trig_sel ? trig_ext : trig_int;
    assign pend_any = |pend;

    // ascending scan, last hit wins: highest index
    always_comb begin
        next_ch = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i]) next_ch = CH_W'(i);
        end
    end

    assign clr = take ? (NCH'(1) << next_ch) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | (load ? mask : '0);
    end

    p_take_pending_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> pend_any);
    p_bit_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> !pend[$past(next_ch)]);

endmodule

// File: rtl/queue_src.sv
module queue_src #(
    parameter int DEPTH = 4,
    parameter int CH_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [CH_W-1:0] wr_ch,
    input  logic            pop,
    output logic            nonempty,
    output logic [CH_W-1:0] head_ch,
    output logic            full,
    output logic            ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CH_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             accept;

    assign full     = (count == CNT_W'(DEPTH));
    assign nonempty = (count != '0);
    assign head_ch  = slots[rd_ptr];
    assign accept   = wr && !full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) begin
                slots[wr_ptr] <= wr_ch;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(accept) - CNT_W'(pop);
            if (wr && full) ovf <= 1'b1;
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && full) |=> ovf);
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import adc_arb_pkg::*;
(
    input  logic              ins_vld,
    input  logic              que_vld,
    input  logic              scn_vld,
    input  logic [PRIO_W-1:0] que_prio,
    input  logic [PRIO_W-1:0] scn_prio,
    output grant_t            grant,
    output logic              any
);
    always_comb begin
        grant = '0;
        if (ins_vld)
            grant.ins = 1'b1;
        else if (que_vld && (!scn_vld || queue_beats_scan(que_prio, scn_prio)))
            grant.que = 1'b1;
        else if (scn_vld)
            grant.scn = 1'b1;
    end

    assign any = ins_vld | que_vld | scn_vld;

endmodule

// File: rtl/adc_req_arbiter.sv
module adc_req_arbiter
    import adc_arb_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int QDEPTH = 4,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic [PRIO_W-1:0] scan_prio,
    input  logic              scan_trig_sel,
    input  logic              scan_trig_int,
    input  logic              scan_trig_ext,
    input  logic [NCH-1:0]    scan_mask,
    input  logic              q_en,
    input  logic [PRIO_W-1:0] q_prio,
    input  logic              q_wr,
    input  logic [CH_W-1:0]   q_ch,
    output logic              q_full,
    output logic              q_ovf,
    input  logic              ins_req,
    input  logic [CH_W-1:0]   ins_ch,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    output logic [1:0]        conv_src,
    input  logic              conv_done
);
    logic            busy;
    logic            ins_pend;
    logic [CH_W-1:0] ins_hold;
    logic            s_any, q_ne;
    logic [CH_W-1:0] s_ch, q_head;
    grant_t          grant;
    logic            any_req, fire;
    logic            take_s, take_q, take_i;

    scan_src #(.NCH(NCH), .CH_W(CH_W)) u_scan (
        .clk(clk), .rst(rst),
        .trig_sel(scan_trig_sel), .trig_int(scan_trig_int), .trig_ext(scan_trig_ext),
        .mask(scan_mask), .take(take_s),
        .pend_any(s_any), .next_ch(s_ch)
    );

    queue_src #(.DEPTH(QDEPTH), .CH_W(CH_W)) u_queue (
        .clk(clk), .rst(rst),
        .wr(q_wr), .wr_ch(q_ch), .pop(take_q),
        .nonempty(q_ne), .head_ch(q_head), .full(q_full), .ovf(q_ovf)
    );

    arb_pick u_pick (
        .ins_vld(ins_pend), .que_vld(q_en && q_ne), .scn_vld(scan_en && s_any),
        .que_prio(q_prio), .scn_prio(scan_prio),
        .grant(grant), .any(any_req)
    );

    assign fire   = !busy && any_req;
    assign take_s = fire && grant.scn;
    assign take_q = fire && grant.que;
    assign take_i = fire && grant.ins;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_ch    <= '0;
            conv_src   <= SRC_SCAN;
            ins_pend   <= 1'b0;
            ins_hold   <= '0;
        end else begin
            conv_start <= fire;
            if (fire) begin
                busy <= 1'b1;
                if (grant.ins) begin
                    conv_ch  <= ins_hold;
                    conv_src <= SRC_INSERT;
                end else if (grant.que) begin
                    conv_ch  <= q_head;
                    conv_src <= SRC_QUEUE;
                end else begin
                    conv_ch  <= s_ch;
                    conv_src <= SRC_SCAN;
                end
            end else if (busy && conv_done) begin
                busy <= 1'b0;
            end
            if (take_i) begin
                ins_pend <= 1'b0;
            end else if (ins_req && !ins_pend) begin
                ins_pend <= 1'b1;
                ins_hold <= ins_ch;
            end
        end
    end

    p_no_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> !conv_start);
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    p_insert_first_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_pend && !busy) |=> (conv_start && conv_src == SRC_INSERT));
    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_s, take_q, take_i}));
    p_src_code_r10: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (conv_src != 2'd3));

endmodule

// File: tb/adc_req_arbiter_bench.sv
module adc_req_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 0, scan_trig_sel = 0, scan_trig_int = 0, scan_trig_ext = 0;
    logic [1:0]  scan_prio = 0, q_prio = 0;
    logic [15:0] scan_mask = 0;
    logic        q_en = 0, q_wr = 0, ins_req = 0, conv_done = 0;
    logic [3:0]  q_ch = 0, ins_ch = 0;
    logic        q_full, q_ovf, conv_start;
    logic [3:0]  conv_ch;
    logic [1:0]  conv_src;

    always #10 clk = ~clk;

    adc_req_arbiter u_adc_req_arbiter (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_prio(scan_prio),
        .scan_trig_sel(scan_trig_sel), .scan_trig_int(scan_trig_int),
        .scan_trig_ext(scan_trig_ext), .scan_mask(scan_mask),
        .q_en(q_en), .q_prio(q_prio), .q_wr(q_wr), .q_ch(q_ch),
        .q_full(q_full), .q_ovf(q_ovf), .ins_req(ins_req), .ins_ch(ins_ch),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_src(conv_src),
        .conv_done(conv_done)
    );

    int checks = 0, fails = 0, starts = 0, cycles = 0;
    bit finished = 0, outstanding = 0;
    int dly = 0;
    logic [5:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic [1:0] src, input logic [3:0] ch);
        exp_q.push_back({src, ch});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: scoreboard compare, converter model
    always @(negedge clk) begin
        cycles++;
        conv_done <= 1'b0;
        if (!rst && conv_start) begin
            starts++;
            check(!outstanding, "R9 start during busy", 1, 0);
            if (exp_q.size() == 0) begin
                check(0, "R3/R4 unexpected start", {conv_src, conv_ch}, 0);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check({conv_src, conv_ch} == e, "R10 src/ch order",
                      {conv_src, conv_ch}, e);
            end
            outstanding = 1;
            dly = 3;
        end else if (outstanding) begin
            dly--;
            if (dly == 0) begin
                conv_done <= 1'b1;
                outstanding = 0;
            end
        end
        if (cycles > 20000) begin
            check(0, "watchdog", cycles, 20000);
            summary();
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || outstanding) tick();
        tick(4);
    endtask

    task automatic scan_fire(input bit ext, input logic [15:0] m);
        scan_mask = m;
        if (ext) scan_trig_ext = 1; else scan_trig_int = 1;
        tick();
        scan_trig_ext = 0; scan_trig_int = 0; scan_mask = 0;
    endtask

    task automatic q_push(input logic [3:0] c);
        q_wr = 1; q_ch = c; tick(); q_wr = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick();
        // R1
        check(conv_start == 0, "R1 start after reset", conv_start, 0);
        check(q_full == 0, "R1 q_full after reset", q_full, 0);
        check(q_ovf == 0, "R1 q_ovf after reset", q_ovf, 0);
        tick(5);
        check(starts == 0, "R1 idle after reset", starts, 0);

        // R2: unselected trigger ignored
        scan_en = 1; scan_trig_sel = 0;
        scan_fire(1, 16'h0010);
        tick(10);
        check(starts == 0, "R2 ext trigger ignored", starts, 0);
        // R2/R3: selected internal trigger, highest first
        expect_item(0, 5); expect_item(0, 2); expect_item(0, 0);
        scan_fire(0, 16'h0025);
        drain();
        check(starts == 3, "R3 scan count", starts, 3);
        // R2: external selected
        scan_trig_sel = 1;
        expect_item(0, 3);
        scan_fire(1, 16'h0008);
        scan_fire(0, 16'h0040);
        drain();
        check(starts == 4, "R2 int ignored when ext selected", starts, 4);
        scan_trig_sel = 0;

        // R4/R10: queue order
        q_en = 1;
        expect_item(1, 3); expect_item(1, 9); expect_item(1, 1);
        q_push(3); q_push(9); q_push(1);
        drain();

        // R5: overflow
        q_en = 0;
        q_push(10); q_push(11); q_push(12); q_push(13);
        check(q_full == 1, "R5 full at 4", q_full, 1);
        check(q_ovf == 0, "R5 no ovf yet", q_ovf, 0);
        q_push(14);
        check(q_ovf == 1, "R5 ovf on refused write", q_ovf, 1);
        expect_item(1, 10); expect_item(1, 11); expect_item(1, 12); expect_item(1, 13);
        q_en = 1;
        drain();
        check(q_full == 0, "R5 drained", q_full, 0);
        check(q_ovf == 1, "R5 ovf sticky", q_ovf, 1);

        // R6: higher priority scan wins
        q_en = 0; scan_en = 0;
        scan_prio = 2; q_prio = 1;
        scan_fire(0, 16'h0300);
        q_push(2); q_push(7);
        expect_item(0, 9); expect_item(0, 8); expect_item(1, 2); expect_item(1, 7);
        q_en = 1; scan_en = 1;
        drain();
        // R6: tie, queue wins
        q_en = 0; scan_en = 0;
        scan_prio = 1; q_prio = 1;
        scan_fire(0, 16'h0011);
        q_push(6);
        expect_item(1, 6); expect_item(0, 4); expect_item(0, 0);
        q_en = 1; scan_en = 1;
        drain();

        // R7: insertion mid-scan, second request ignored
        begin
            int s0;
            s0 = starts;
            expect_item(0, 7); expect_item(2, 12);
            expect_item(0, 6); expect_item(0, 5); expect_item(0, 4);
            scan_fire(0, 16'h00F0);
            while (starts == s0) tick();
            ins_req = 1; ins_ch = 12; tick();
            ins_ch = 1; tick();
            ins_req = 0;
            drain();
            check(starts == s0 + 5, "R7 one insert only", starts - s0, 5);
        end

        // R8: disabled source keeps pending
        begin
            int s0;
            s0 = starts;
            scan_en = 0;
            scan_fire(0, 16'h0003);
            tick(20);
            check(starts == s0, "R8 disabled not granted", starts - s0, 0);
            expect_item(0, 1); expect_item(0, 0);
            scan_en = 1;
            drain();
            check(starts == s0 + 2, "R8 resumed", starts - s0, 2);
        end

        check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
        summary();
    end
endmodule